// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer. It is clocked by the output of a 16/17 prescaler. The prescaler itself divides the oscillator. The block steers that prescaler through a modulus-control output, so that the complete chain divides the oscillator by a 14-bit ratio M. Once per M oscillator cycles it issues one comparison pulse to the phase detector.

Two ratio registers are held outside the block. A bank-select input chooses which of them is used, so a system can switch between two channel plans. The chosen ratio is split into two fields. The low field counts the prescaler cycles run at divide-by-17. The high field counts the prescaler cycles in one output period. Together they give M = 16·P + A. The ratio is sampled only at the boundary between two output periods. This means a change made while a period is running never disturbs it.

Top module: `fbdiv_dual_modulus`

## Requirements
- R1: While rst_n is low, mod_ctl and cmp_pulse are both low. When rst_n rises with a ratio of program field P applied, the first cmp_pulse is high in prescaler cycle 2+P, counting the first rising clk edge after release as cycle 1.
- R2: When bank_sel is 0 the ratio comes from ratio_a. When bank_sel is 1 it comes from ratio_b. Both are 14-bit unsigned values.
- R3: The swallow field A is bits [3:0] of the chosen ratio. The program field P is bits [13:4].
- R4: In every output period, mod_ctl is 1 (divide by 17) for exactly the first A prescaler cycles and 0 (divide by 16) for the remaining cycles. It never rises again inside the same period.
- R5: Every output period lasts exactly P prescaler cycles. Periods follow one another with no gap, so each one spans 16·P + A oscillator cycles.
- R6: cmp_pulse is high for exactly one prescaler cycle, the last cycle of each period. mod_ctl is 0 in that cycle.
- R7: The ratio inputs and bank_sel are sampled only at the clock edge that ends a period. Changes made at any other time have no effect on the running period.
- R8: A chosen ratio below 256 is treated as 256, giving P = 16 and A = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_sel | input | 1 | Chooses ratio_a (0) or ratio_b (1) |
| ratio_a | input | 14 | First ratio register value |
| ratio_b | input | 14 | Second ratio register value |
| mod_ctl | output | 1 | Prescaler modulus: 1 = divide by 17, 0 = divide by 16 |
| cmp_pulse | output | 1 | One-cycle comparison event to the phase detector |

## Verification
The assertions take for granted that the program field is always larger than the swallow field. This holds only because ratios below 256 are floored, so every input pattern, including a ratio of zero, must still yield at least sixteen prescaler cycles per period. The stimulus drives every 14-bit value freely, including values under the floor. It rewrites the ratios and bank_sel at random points inside a period. This exercises the floor and the boundary sampling rather than avoiding them. All input changes are made half a cycle away from the sampling edge.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int unsigned DEF_SWALLOW_W = 4;
  localparam int unsigned DEF_PROG_W    = 10;
  localparam int unsigned DEF_SYNC_N    = 2;

  typedef enum logic {
    MOD_BASE  = 1'b0,
    MOD_PLUS1 = 1'b1
  } modulus_e;
endpackage

// File: rtl/fbdiv_rst_sync.sv
module fbdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/fbdiv_ratio_sel.sv
module fbdiv_ratio_sel #(
  parameter int unsigned SW = 4,
  parameter int unsigned PW = 10
) (
  input  logic             sel,
  input  logic [SW+PW-1:0] ratio_a,
  input  logic [SW+PW-1:0] ratio_b,
  output logic [SW-1:0]    swallow_ld,
  output logic [PW-1:0]    prog_ld
);
  localparam int unsigned MW = SW + PW;
  localparam logic [MW-1:0] M_MIN = MW'(1) << (2 * SW);
  localparam logic [PW-1:0] P_MIN = PW'(1) << SW;

  logic [MW-1:0] picked;
  logic [MW-1:0] floored;

  always_comb begin
    picked     = sel ? ratio_b : ratio_a;
    floored    = (picked < M_MIN) ? M_MIN : picked;
    swallow_ld = floored[SW-1:0];
    prog_ld    = floored[MW-1:SW];
  end

  always_comb begin
    AST_P_FLOOR: assert (prog_ld >= P_MIN)  // R8
      else $error("program load below floor");
  end
endmodule

// File: rtl/fbdiv_prog_ctr.sv
module fbdiv_prog_ctr #(
  parameter int unsigned SW = 4,
  parameter int unsigned PW = 10
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [PW-1:0] load_val,
  output logic          end_cycle,
  output logic          cmp_pulse
);
  localparam int unsigned P_MIN = 1 << SW;

  logic          armed_q, armed_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en    = 1'b1;
    end_cycle = !armed_q || (cnt_q == '0);
    cmp_pulse = armed_q && (cnt_q == '0);
    armed_d   = 1'b1;
    cnt_d     = end_cycle ? (load_val - 1'b1) : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_LOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_ni)
    end_cycle |=> (cnt_q >= PW'(P_MIN - 1)))  // R8
    else $error("program count loaded below floor");
endmodule

// File: rtl/fbdiv_swallow_ctr.sv
module fbdiv_swallow_ctr #(
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          reload,
  input  logic [SW-1:0] load_val,
  output logic          mod_ctl
);
  import fbdiv_pkg::*;

  logic [SW-1:0] a_q, a_d;
  modulus_e      mod_sel;

  always_comb begin
    mod_sel = (a_q != '0) ? MOD_PLUS1 : MOD_BASE;
    if (reload)              a_d = load_val;
    else if (mod_sel == MOD_PLUS1) a_d = a_q - 1'b1;
    else                     a_d = a_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) a_q <= '0;
    else         a_q <= a_d;
  end

  assign mod_ctl = (mod_sel == MOD_PLUS1);
endmodule

// File: rtl/fbdiv_dual_modulus.sv
module fbdiv_dual_modulus #(
  parameter int unsigned SWALLOW_W = fbdiv_pkg::DEF_SWALLOW_W,
  parameter int unsigned PROG_W    = fbdiv_pkg::DEF_PROG_W,
  parameter int unsigned SYNC_N    = fbdiv_pkg::DEF_SYNC_N
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bank_sel,
  input  logic [SWALLOW_W+PROG_W-1:0] ratio_a,
  input  logic [SWALLOW_W+PROG_W-1:0] ratio_b,
  output logic                        mod_ctl,
  output logic                        cmp_pulse
);
  logic                 rst_i_n;
  logic [SWALLOW_W-1:0] swallow_ld;
  logic [PROG_W-1:0]    prog_ld;
  logic                 end_cycle;

  fbdiv_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_i_n)
  );

  fbdiv_ratio_sel #(.SW(SWALLOW_W), .PW(PROG_W)) u_sel (
    .sel        (bank_sel),
    .ratio_a    (ratio_a),
    .ratio_b    (ratio_b),
    .swallow_ld (swallow_ld),
    .prog_ld    (prog_ld)
  );

  fbdiv_prog_ctr #(.SW(SWALLOW_W), .PW(PROG_W)) u_prog (
    .clk       (clk),
    .rst_ni    (rst_i_n),
    .load_val  (prog_ld),
    .end_cycle (end_cycle),
    .cmp_pulse (cmp_pulse)
  );

  fbdiv_swallow_ctr #(.SW(SWALLOW_W)) u_swal (
    .clk      (clk),
    .rst_ni   (rst_i_n),
    .reload   (end_cycle),
    .load_val (swallow_ld),
    .mod_ctl  (mod_ctl)
  );

  AST_SWALLOW_DONE: assert property (@(posedge clk) disable iff (!rst_i_n)
    cmp_pulse |-> !mod_ctl)  // R6
    else $error("modulus still high at period end");

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    cmp_pulse |=> !cmp_pulse)  // R6
    else $error("comparison pulse longer than one cycle");

  AST_MOD_CONTIG: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!mod_ctl && !end_cycle) |=> !mod_ctl)  // R4
    else $error("modulus rose inside a period");
endmodule

// File: tb/fbdiv_dual_modulus_test.sv
module fbdiv_dual_modulus_test;
  localparam int SYNC   = 2;
  localparam int TARGET = 60;
  localparam int LIMIT  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_sel = 1'b0;
  logic [13:0] ratio_a = '0;
  logic [13:0] ratio_b = '0;
  logic        mod_ctl, cmp_pulse;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  fbdiv_dual_modulus uut (
    .clk (clk), .rst_n (rst_n), .bank_sel (bank_sel),
    .ratio_a (ratio_a), .ratio_b (ratio_b),
    .mod_ctl (mod_ctl), .cmp_pulse (cmp_pulse)
  );

  function automatic int floor_m(input int m);
    return (m < 256) ? 256 : m;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int m, input bit s);
    bank_sel = s;
    if (s) begin ratio_b = 14'(m); ratio_a = 14'($urandom_range(0, 16383)); end
    else   begin ratio_a = 14'(m); ratio_b = 14'($urandom_range(0, 16383)); end
  endtask

  task automatic pick(input int idx, output int m, output bit s);
    case (idx)
      0: begin m = 16383; s = 1'b1; end
      1: begin m = 0;     s = 1'b0; end
      2: begin m = 255;   s = 1'b1; end
      3: begin m = 256;   s = 1'b0; end
      4: begin m = 271;   s = 1'b1; end
      5: begin m = 4096;  s = 1'b0; end
      6: begin m = 5000;  s = 1'b1; end
      7: begin m = 17;    s = 1'b0; end
      default: begin
        if ($urandom_range(0, 3) == 0) m = $urandom_range(0, 300);
        else                           m = $urandom_range(0, 16383);
        s = 1'($urandom_range(0, 1));
      end
    endcase
  endtask

  initial begin
    int  n = 0, cyc_in = 0, vco = 0, ones = 0, periods = 0, idx = 0;
    int  exp_m = 0, exp_raw = 0, m = 0;
    bit  s = 1'b0, seen = 1'b0, dropped = 1'b0, contig_err = 1'b0;
    bit  scr = 1'b0, prev_pulse = 1'b0;
    void'($urandom(32'd2718));

    apply(300, 1'b0);
    repeat (3) begin
      @(negedge clk);
      chk(cmp_pulse == 1'b0, "R1", cmp_pulse, 0);
      chk(mod_ctl == 1'b0, "R1", mod_ctl, 0);
    end
    rst_n = 1'b1;

    while (periods < TARGET && n < LIMIT) begin
      @(negedge clk);
      n++;
      if (prev_pulse) chk(cmp_pulse == 1'b0, "R6", cmp_pulse, 0);
      prev_pulse = cmp_pulse;
      if (!seen) begin
        if (cmp_pulse) begin
          chk(n == SYNC + 18, "R1", n, SYNC + 18);
          chk(mod_ctl == 1'b0, "R6", mod_ctl, 0);
          seen = 1'b1;
          pick(idx, m, s); idx++; apply(m, s);
          exp_raw = m; exp_m = floor_m(m);
          cyc_in = 0; vco = 0; ones = 0; dropped = 0; contig_err = 0; scr = 0;
        end
      end else begin
        cyc_in++;
        vco  += 16 + int'(mod_ctl);
        ones += int'(mod_ctl);
        if (mod_ctl && dropped) contig_err = 1'b1;
        if (!mod_ctl) dropped = 1'b1;
        if (cmp_pulse) begin
          chk(cyc_in == (exp_m >> 4), "R5", cyc_in, exp_m >> 4);
          chk(ones == (exp_m & 15), "R3", ones, exp_m & 15);
          chk(!contig_err, "R4", int'(contig_err), 0);
          chk(mod_ctl == 1'b0, "R6", mod_ctl, 0);
          if (exp_raw < 256) chk(vco == exp_m, "R8", vco, exp_m);
          else if (scr)      chk(vco == exp_m, "R7", vco, exp_m);
          else               chk(vco == exp_m, "R2", vco, exp_m);
          periods++;
          pick(idx, m, s); idx++; apply(m, s);
          exp_raw = m; exp_m = floor_m(m);
          cyc_in = 0; vco = 0; ones = 0; dropped = 0; contig_err = 0; scr = 0;
        end else if ($urandom_range(0, 15) == 0) begin
          bank_sel = 1'($urandom_range(0, 1));
          ratio_a  = 14'($urandom_range(0, 16383));
          ratio_b  = 14'($urandom_range(0, 16383));
          scr = 1'b1;
        end
      end
    end

    if (n >= LIMIT) chk(1'b0, "R5 watchdog", periods, TARGET);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule